// File: doc/BRIEF.md
# Ping-pong serial DMA controller

This block sequences the DMA engine of a byte-wide serial peripheral. The receive and transmit directions are independent, and each one has two buffers, A and B. Software programs a start address and an end address for a buffer and then writes a one to that buffer's load bit in the control register. The engine copies the address pair at that moment and moves bytes between memory and the serial shifter until it has moved the byte at the end address. Then it drops the load bit, pulses that buffer's done line, and goes straight on to the other buffer if that buffer is armed.

The load bits are also the status. A load bit reads one while its buffer is waiting or in progress. Each direction also has a reset bit that clears itself. On the receive side the engine writes each byte that the shifter strobes into memory. On the transmit side it reads one byte ahead and holds it until the shifter signals that it is ready.

Top module: `pp_dma_ctrl`

## Requirements
- R1: After the synchronous reset all load bits read zero, no memory write or read request is issued, and no transmit byte is offered.
- R2: The control write uses these bit positions: 0 loads receive A, 1 loads receive B, 2 loads transmit A, 3 loads transmit B, 4 resets the receive direction and 5 resets the transmit direction. Read data bits 3:0 give the four load bits in the same positions, and bits 5:4 read zero. A one written to a load bit reads back one from the next cycle.
- R3: A zero written to a load bit changes nothing. A load bit falls only when its buffer completes or when its direction is reset.
- R4: When the byte at a buffer's end address is moved, that buffer's load bit clears. In the same cycle its done line pulses high for exactly one cycle.
- R5: While a receive buffer is active, each cycle with a byte strobe gives one memory write in the next cycle, at consecutive addresses starting at the latched start address. Strobes while no receive buffer is active write nothing.
- R6: A transmit buffer reads memory one address at a time, and the read data returns one cycle after the request. The fetched byte stays on the byte output, unchanged, until the shifter's ready is seen.
- R7: When both buffers of a direction are armed, the engine serves them in the order they were armed. The second buffer takes a byte in the cycle right after the first buffer completes.
- R8: If both load bits of an idle direction are set in the same write, buffer A is served first.
- R9: A direction's reset bit clears both of its load bits and its address pointer, and drops any fetched byte. The other direction is unaffected. The reset bits clear themselves.
- R10: A write that sets a load bit and the reset bit of the same direction leaves that load bit at zero.
- R11: The address pair is latched when the buffer is armed. Rewriting the address registers while the buffer runs does not change its transfer.
- R12: A one written to a load bit that already reads one is ignored. The running transfer is neither restarted nor extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 6 | Control write data (load and reset bits) |
| ctl_rdata | output | 6 | Load bit status, reset bits read zero |
| cfg_we | input | 1 | Address register write strobe |
| cfg_sel | input | 3 | Bit 2 direction (1 = transmit), bit 1 buffer (1 = B), bit 0 end (1) or start (0) |
| cfg_wdata | input | AW | Address register write data |
| rx_byte_valid | input | 1 | Shifter has a received byte |
| rx_byte | input | DW | Received byte |
| rx_mem_we | output | 1 | Memory write request |
| rx_mem_addr | output | AW | Memory write address |
| rx_mem_wdata | output | DW | Memory write data |
| rx_done | output | 2 | Receive buffer done pulses (bit 0 A, bit 1 B) |
| tx_mem_req | output | 1 | Memory read request |
| tx_mem_addr | output | AW | Memory read address |
| tx_mem_rdata | input | DW | Read data, valid the cycle after the request |
| tx_ready | input | 1 | Shifter takes the offered byte |
| tx_byte_valid | output | 1 | A transmit byte is offered |
| tx_byte | output | DW | Offered transmit byte |
| tx_done | output | 2 | Transmit buffer done pulses (bit 0 A, bit 1 B) |

## Verification
The bench builds the block with an 8-bit address and 8-bit data. Its buffers are one to four bytes long, so completions, the A-to-B handover and repeated arming all occur many times within a few hundred cycles. The narrow pointer keeps every address the reference model tracks small and easy to read in a failure line. The transmit shifter stalls on a repeating ready pattern, so a held byte is seen both with and without back-pressure.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;
  // control word bit positions
  localparam int CTL_W      = 6;
  localparam int RX_LD_A    = 0;
  localparam int RX_LD_B    = 1;
  localparam int TX_LD_A    = 2;
  localparam int TX_LD_B    = 3;
  localparam int RX_RST     = 4;
  localparam int TX_RST     = 5;
  // address register select bit positions
  localparam int CFG_END_BIT = 0;
  localparam int CFG_BUF_BIT = 1;
  localparam int CFG_DIR_BIT = 2;
  localparam int NUM_DIR     = 2;
  localparam int NUM_BUF     = 2;
endpackage

// File: rtl/pp_dma_chan.sv
module pp_dma_chan
  import pp_dma_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dir_rst,
  input  logic [NUM_BUF-1:0]      arm,
  input  logic                    cfg_we,
  input  logic                    cfg_buf,
  input  logic                    cfg_end,
  input  logic [AW-1:0]           cfg_data,
  input  logic                    step,
  output logic [NUM_BUF-1:0]      load,
  output logic                    active,
  output logic [AW-1:0]           ptr,
  output logic [NUM_BUF-1:0]      done
);
  logic [NUM_BUF-1:0][AW-1:0] stg_s, stg_e, lat_s, lat_e;
  logic [NUM_BUF-1:0] arm_ok, load_n, done_n;
  logic               cur, cur_n, nsel, fin;
  logic [AW-1:0]      ptr_n;

  assign arm_ok = arm & ~load & {NUM_BUF{~dir_rst}};

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [AW-1:0] s_q, e_q, ls_q, le_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        s_q <= '0;
        e_q <= '0;
      end else if (cfg_we && (cfg_buf == 1'(b))) begin
        if (cfg_end) e_q <= cfg_data;
        else         s_q <= cfg_data;
      end
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        ls_q <= '0;
        le_q <= '0;
      end else if (arm_ok[b]) begin
        ls_q <= s_q;
        le_q <= e_q;
      end
    end
    assign stg_s[b] = s_q;
    assign stg_e[b] = e_q;
    assign lat_s[b] = ls_q;
    assign lat_e[b] = le_q;
  end

  assign active = load[cur];
  assign fin    = step & active & (ptr == lat_e[cur]);

  always_comb begin
    load_n = load | arm_ok;
    done_n = '0;
    cur_n  = cur;
    ptr_n  = ptr;
    nsel   = cur;
    if (fin) begin
      load_n[cur] = 1'b0;
      done_n[cur] = 1'b1;
    end else if (step && active) begin
      ptr_n = ptr + 1'b1;
    end
    if (!active || fin) begin
      nsel = fin ? ~cur : (load_n[0] ? 1'b0 : 1'b1);
      if (load_n[nsel]) begin
        cur_n = nsel;
        ptr_n = arm_ok[nsel] ? stg_s[nsel] : lat_s[nsel];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || dir_rst) begin
      load <= '0;
      cur  <= 1'b0;
      ptr  <= '0;
      done <= '0;
    end else begin
      load <= load_n;
      cur  <= cur_n;
      ptr  <= ptr_n;
      done <= done_n;
    end
  end
endmodule

// File: rtl/pp_dma_rx.sv
module pp_dma_rx #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_rst,
  input  logic          active,
  input  logic [AW-1:0] ptr,
  input  logic          byte_valid,
  input  logic [DW-1:0] byte_in,
  output logic          step,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  assign step = active & byte_valid & ~dir_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= step;
      if (step) begin
        mem_addr  <= ptr;
        mem_wdata <= byte_in;
      end
    end
  end
endmodule

// File: rtl/pp_dma_tx.sv
module pp_dma_tx #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_rst,
  input  logic          active,
  input  logic [AW-1:0] ptr,
  input  logic [DW-1:0] mem_rdata,
  input  logic          shf_ready,
  output logic          step,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          byte_valid,
  output logic [DW-1:0] byte_out
);
  logic wait_q, issue;

  assign step  = byte_valid & shf_ready & ~dir_rst;
  assign issue = active & ~byte_valid & ~mem_req & ~wait_q;

  always_ff @(posedge clk) begin
    if (rst || dir_rst) begin
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      wait_q     <= 1'b0;
      byte_valid <= 1'b0;
      byte_out   <= '0;
    end else begin
      mem_req <= issue;
      if (issue) mem_addr <= ptr;
      wait_q <= mem_req;
      if (wait_q) begin
        byte_valid <= 1'b1;
        byte_out   <= mem_rdata;
      end else if (step) begin
        byte_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pp_dma_ctrl.sv
module pp_dma_ctrl
  import pp_dma_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             rx_byte_valid,
  input  logic [DW-1:0]    rx_byte,
  output logic             rx_mem_we,
  output logic [AW-1:0]    rx_mem_addr,
  output logic [DW-1:0]    rx_mem_wdata,
  output logic [1:0]       rx_done,
  output logic             tx_mem_req,
  output logic [AW-1:0]    tx_mem_addr,
  input  logic [DW-1:0]    tx_mem_rdata,
  input  logic             tx_ready,
  output logic             tx_byte_valid,
  output logic [DW-1:0]    tx_byte,
  output logic [1:0]       tx_done
);
  localparam int RXD = 0;
  localparam int TXD = 1;

  logic [NUM_DIR-1:0][NUM_BUF-1:0] arm_d, load_d, done_d;
  logic [NUM_DIR-1:0]              drst_d, act_d, step_d;
  logic [NUM_DIR-1:0][AW-1:0]      ptr_d;

  assign arm_d[RXD] = {ctl_wdata[RX_LD_B], ctl_wdata[RX_LD_A]} & {NUM_BUF{ctl_we}};
  assign arm_d[TXD] = {ctl_wdata[TX_LD_B], ctl_wdata[TX_LD_A]} & {NUM_BUF{ctl_we}};
  assign drst_d[RXD] = ctl_we & ctl_wdata[RX_RST];
  assign drst_d[TXD] = ctl_we & ctl_wdata[TX_RST];

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    pp_dma_chan #(.AW(AW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .dir_rst  (drst_d[d]),
      .arm      (arm_d[d]),
      .cfg_we   (cfg_we && (cfg_sel[CFG_DIR_BIT] == 1'(d))),
      .cfg_buf  (cfg_sel[CFG_BUF_BIT]),
      .cfg_end  (cfg_sel[CFG_END_BIT]),
      .cfg_data (cfg_wdata),
      .step     (step_d[d]),
      .load     (load_d[d]),
      .active   (act_d[d]),
      .ptr      (ptr_d[d]),
      .done     (done_d[d])
    );
  end

  pp_dma_rx #(.AW(AW), .DW(DW)) u_rx (
    .clk        (clk),
    .rst        (rst),
    .dir_rst    (drst_d[RXD]),
    .active     (act_d[RXD]),
    .ptr        (ptr_d[RXD]),
    .byte_valid (rx_byte_valid),
    .byte_in    (rx_byte),
    .step       (step_d[RXD]),
    .mem_we     (rx_mem_we),
    .mem_addr   (rx_mem_addr),
    .mem_wdata  (rx_mem_wdata)
  );

  pp_dma_tx #(.AW(AW), .DW(DW)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .dir_rst    (drst_d[TXD]),
    .active     (act_d[TXD]),
    .ptr        (ptr_d[TXD]),
    .mem_rdata  (tx_mem_rdata),
    .shf_ready  (tx_ready),
    .step       (step_d[TXD]),
    .mem_req    (tx_mem_req),
    .mem_addr   (tx_mem_addr),
    .byte_valid (tx_byte_valid),
    .byte_out   (tx_byte)
  );

  assign ctl_rdata = {2'b00, load_d[TXD], load_d[RXD]};
  assign rx_done   = done_d[RXD];
  assign tx_done   = done_d[TXD];
endmodule

// File: rtl/pp_dma_ctrl_chk.sv
module pp_dma_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_we,
  input logic [5:0]    ctl_wdata,
  input logic [5:0]    ctl_rdata,
  input logic          rx_byte_valid,
  input logic          rx_mem_we,
  input logic [1:0]    rx_done,
  input logic          tx_mem_req,
  input logic          tx_ready,
  input logic          tx_byte_valid,
  input logic [DW-1:0] tx_byte,
  input logic [1:0]    tx_done
);
  // R9
  rx_rst_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[4]) |=> (ctl_rdata[1:0] == 2'b00));
  // R10
  tx_rst_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[5]) |=> (ctl_rdata[3:2] == 2'b00 && !tx_byte_valid && !tx_mem_req));
  // R3
  rxa_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_rdata[0]) |-> (rx_done[0] || $past(ctl_we && ctl_wdata[4])));
  // R3
  txb_fall_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctl_rdata[3]) |-> (tx_done[1] || $past(ctl_we && ctl_wdata[5])));
  // R4
  rx_done_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rx_done) && $onehot0(tx_done));
  // R4
  rx_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rx_done[0] |=> !rx_done[0]);
  // R5
  rx_write_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rx_mem_we |-> $past(rx_byte_valid && (ctl_rdata[1:0] != 2'b00)));
  // R6
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_byte_valid && !tx_ready && !(ctl_we && ctl_wdata[5])) |=> (tx_byte_valid && $stable(tx_byte)));
  // R6
  tx_req_single_chk: assert property (@(posedge clk) disable iff (rst)
    tx_mem_req |=> !tx_mem_req);
endmodule

bind pp_dma_ctrl pp_dma_ctrl_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ctl_we        (ctl_we),
  .ctl_wdata     (ctl_wdata),
  .ctl_rdata     (ctl_rdata),
  .rx_byte_valid (rx_byte_valid),
  .rx_mem_we     (rx_mem_we),
  .rx_done       (rx_done),
  .tx_mem_req    (tx_mem_req),
  .tx_ready      (tx_ready),
  .tx_byte_valid (tx_byte_valid),
  .tx_byte       (tx_byte),
  .tx_done       (tx_done)
);

// File: tb/test_pp_dma_ctrl.sv
module test_pp_dma_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ctl_we = 1'b0;
  logic [5:0]    ctl_wdata = '0;
  logic [5:0]    ctl_rdata;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          rx_byte_valid = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          rx_mem_we;
  logic [AW-1:0] rx_mem_addr;
  logic [DW-1:0] rx_mem_wdata;
  logic [1:0]    rx_done;
  logic          tx_mem_req;
  logic [AW-1:0] tx_mem_addr;
  logic [DW-1:0] tx_mem_rdata = '0;
  logic          tx_ready = 1'b0;
  logic          tx_byte_valid;
  logic [DW-1:0] tx_byte;
  logic [1:0]    tx_done;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pp_dma_ctrl #(.AW(AW), .DW(DW)) i_pp_dma_ctrl (.*);

  function automatic logic [DW-1:0] memfn(input logic [AW-1:0] a);
    return DW'(a * 13 + 5);
  endfunction

  always @(posedge clk) if (tx_mem_req) tx_mem_rdata <= memfn(tx_mem_addr);

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [AW-1:0] m_stg [2][2][2];
  logic [AW-1:0] m_ls [2][2];
  logic [AW-1:0] m_le [2][2];
  logic [AW-1:0] m_ptr [2];
  bit            m_ld [2][2];
  bit            m_done [2][2];
  int            m_ord [2][2];
  int            m_cnt [2];
  bit            e_rx_we, m_treq, m_twt, m_tvld;
  logic [AW-1:0] e_rx_addr, m_taddr;
  logic [DW-1:0] e_rx_data, m_tbyte;

  task automatic seq_update(input int d, input bit stp, input bit rb, input bit [1:0] arm);
    bit old0, old1;
    int c;
    if (rb) begin
      m_cnt[d] = 0; m_ld[d][0] = 0; m_ld[d][1] = 0; m_ptr[d] = '0;
      return;
    end
    old0 = m_ld[d][0];
    old1 = m_ld[d][1];
    if (stp && m_cnt[d] > 0) begin
      c = m_ord[d][0];
      if (m_ptr[d] == m_le[d][c]) begin
        m_ld[d][c] = 0;
        m_done[d][c] = 1;
        m_ord[d][0] = m_ord[d][1];
        m_cnt[d]--;
        if (m_cnt[d] > 0) m_ptr[d] = m_ls[d][m_ord[d][0]];
      end else begin
        m_ptr[d] = m_ptr[d] + 1'b1;
      end
    end
    for (int b = 0; b < 2; b++) begin
      if (arm[b] && !(b == 0 ? old0 : old1)) begin
        m_ld[d][b] = 1;
        m_ls[d][b] = m_stg[d][b][0];
        m_le[d][b] = m_stg[d][b][1];
        m_ord[d][m_cnt[d]] = b;
        m_cnt[d]++;
        if (m_cnt[d] == 1) m_ptr[d] = m_ls[d][b];
      end
    end
  endtask

  always @(posedge clk) begin
    bit rb_rx, rb_tx, stp, nreq;
    bit [1:0] arm_rx, arm_tx;
    for (int d = 0; d < 2; d++) for (int b = 0; b < 2; b++) m_done[d][b] = 0;
    if (rst) begin
      for (int d = 0; d < 2; d++) begin
        m_cnt[d] = 0; m_ptr[d] = '0;
        for (int b = 0; b < 2; b++) begin
          m_ld[d][b] = 0; m_ls[d][b] = '0; m_le[d][b] = '0;
          m_stg[d][b][0] = '0; m_stg[d][b][1] = '0;
        end
      end
      e_rx_we = 0; m_treq = 0; m_twt = 0; m_tvld = 0;
    end else begin
      rb_rx  = ctl_we && ctl_wdata[4];
      rb_tx  = ctl_we && ctl_wdata[5];
      arm_rx = ctl_we ? ctl_wdata[1:0] : 2'b00;
      arm_tx = ctl_we ? ctl_wdata[3:2] : 2'b00;
      stp = (m_cnt[0] > 0) && rx_byte_valid && !rb_rx;
      e_rx_we = stp;
      if (stp) begin e_rx_addr = m_ptr[0]; e_rx_data = rx_byte; end
      seq_update(0, stp, rb_rx, arm_rx);
      if (rb_tx) begin
        m_treq = 0; m_twt = 0; m_tvld = 0;
        seq_update(1, 0, 1, 2'b00);
      end else begin
        stp  = m_tvld && tx_ready;
        nreq = (m_cnt[1] > 0) && !m_tvld && !m_treq && !m_twt;
        if (m_twt) begin m_tvld = 1; m_tbyte = memfn(m_taddr); m_twt = 0; end
        if (m_treq) m_twt = 1;
        if (stp) m_tvld = 0;
        if (nreq) m_taddr = m_ptr[1];
        m_treq = nreq;
        seq_update(1, stp, 0, arm_tx);
      end
      if (cfg_we) m_stg[cfg_sel[2]][cfg_sel[1]][cfg_sel[0]] = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (!rst && cyc > 1) begin
      chk("R2 load status", 32'(ctl_rdata),
          32'({2'b00, m_ld[1][1], m_ld[1][0], m_ld[0][1], m_ld[0][0]}));
      chk("R5 rx write strobe", 32'(rx_mem_we), 32'(e_rx_we));
      if (e_rx_we) begin
        chk("R5 rx write address", 32'(rx_mem_addr), 32'(e_rx_addr));
        chk("R5 rx write data", 32'(rx_mem_wdata), 32'(e_rx_data));
      end
      chk("R4 rx done", 32'(rx_done), 32'({m_done[0][1], m_done[0][0]}));
      chk("R4 tx done", 32'(tx_done), 32'({m_done[1][1], m_done[1][0]}));
      chk("R6 tx read request", 32'(tx_mem_req), 32'(m_treq));
      if (m_treq) chk("R6 tx read address", 32'(tx_mem_addr), 32'(m_taddr));
      chk("R6 tx byte valid", 32'(tx_byte_valid), 32'(m_tvld));
      if (m_tvld) chk("R6 tx byte", 32'(tx_byte), 32'(m_tbyte));
    end
  end

  // ---------------- observation ----------------
  logic [AW-1:0] rx_log [$];
  logic [DW-1:0] tx_log [$];
  int n_rxd0 = 0, n_txd0 = 0, n_txd1 = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst) begin
      if (rx_mem_we) rx_log.push_back(rx_mem_addr);
      if (tx_byte_valid && tx_ready) tx_log.push_back(tx_byte);
      if (rx_done[0]) n_rxd0++;
      if (tx_done[0]) n_txd0++;
      if (tx_done[1]) n_txd1++;
    end
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog (all requirements) got %0d cycles exp below %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_ctl(input logic [5:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0; ctl_wdata = '0;
  endtask

  task automatic wr_cfg(input logic [2:0] sel, input logic [AW-1:0] v);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rx_feed(input int n, input logic [DW-1:0] base);
    for (int i = 0; i < n; i++) begin
      rx_byte_valid = 1'b1;
      rx_byte = base + DW'(i);
      @(negedge clk);
    end
    rx_byte_valid = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_log(input string tag, input logic [AW-1:0] exp [$]);
    chk({tag, " write count"}, 32'(rx_log.size()), 32'(exp.size()));
    for (int i = 0; i < exp.size() && i < rx_log.size(); i++)
      chk({tag, " write order"}, 32'(rx_log[i]), 32'(exp[i]));
    rx_log.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 load bits after reset", 32'(ctl_rdata), 0);
    chk("R1 no write after reset", 32'(rx_mem_we), 0);
    chk("R1 no tx byte after reset", 32'({tx_mem_req, tx_byte_valid}), 0);

    wr_cfg(3'b000, 8'h10); wr_cfg(3'b001, 8'h13);
    wr_cfg(3'b010, 8'h20); wr_cfg(3'b011, 8'h21);
    wr_cfg(3'b100, 8'h40); wr_cfg(3'b101, 8'h42);
    wr_cfg(3'b110, 8'h50); wr_cfg(3'b111, 8'h50);

    // R5 strobes while idle are dropped
    rx_feed(3, 8'h11);
    chk("R5 idle strobes write nothing", 32'(rx_log.size()), 0);

    // R8 / R7 both armed at once, A first, gapless switch
    wr_ctl(6'h03);
    chk("R2 both receive load bits set", 32'(ctl_rdata), 32'h03);
    rx_feed(6, 8'hA0);
    chk_log("R7 R8", '{8'h10, 8'h11, 8'h12, 8'h13, 8'h20, 8'h21});
    chk("R4 receive load bits clear after completion", 32'(ctl_rdata), 0);

    // R3, R11, R12 while buffer A runs
    wr_ctl(6'h01);
    wr_cfg(3'b000, 8'h30);
    wr_ctl(6'h00);
    chk("R3 zero write keeps load bit", 32'(ctl_rdata[0]), 1);
    wr_ctl(6'h01);
    rx_feed(4, 8'hC0);
    chk_log("R11 R12", '{8'h10, 8'h11, 8'h12, 8'h13});
    chk("R12 rearm while loaded ignored", 32'(ctl_rdata[0]), 0);
    chk("R4 receive A done pulses", 32'(n_rxd0), 2);

    // R9 / R10 direction reset
    wr_cfg(3'b001, 8'h31);
    wr_ctl(6'h05);
    chk("R2 rx A and tx A armed", 32'(ctl_rdata), 32'h05);
    wr_ctl(6'h24);
    chk("R10 reset beats load", 32'(ctl_rdata[3:2]), 0);
    chk("R9 other direction untouched", 32'(ctl_rdata[1:0]), 1);
    wr_ctl(6'h10);
    chk("R9 receive reset clears loads", 32'(ctl_rdata), 0);
    rx_log.delete();
    wr_ctl(6'h02);
    rx_feed(2, 8'h55);
    chk_log("R9 after reset", '{8'h20, 8'h21});

    // R6 transmit with back-pressure, A then B
    tx_log.delete();
    wr_ctl(6'h0C);
    for (int i = 0; i < 60; i++) begin
      tx_ready = (i % 3) != 0;
      @(negedge clk);
    end
    tx_ready = 1'b0;
    @(negedge clk);
    chk("R6 transmit byte count", 32'(tx_log.size()), 4);
    if (tx_log.size() == 4) begin
      chk("R6 first transmit byte", 32'(tx_log[0]), 32'(memfn(8'h40)));
      chk("R6 last A byte", 32'(tx_log[2]), 32'(memfn(8'h42)));
      chk("R7 transmit B byte", 32'(tx_log[3]), 32'(memfn(8'h50)));
    end
    chk("R4 transmit A done", 32'(n_txd0), 1);
    chk("R4 transmit B done", 32'(n_txd1), 1);
    chk("R4 transmit loads clear", 32'(ctl_rdata), 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule